// File: doc/BRIEF.md
# Board System Control Register Bank

This block is a bank of 32-bit control and status words seen through a simple word-wide bus inside a 4 KB address window. Software uses it to set a boot-remap line, drive a row of status LEDs, hold a few board-specific tuning words, read fixed identification values and watch the lock state of the board's clock loops. All accesses are full 32-bit words. A read returns its data in the cycle after the request.

Which optional words exist is fixed when the block is built. The part number in bits [11:4] of the identification value decides it. Two designated part numbers get a pair of extra words, and only the first of them gets a third. A request to any offset that does not exist on the built variant is reported on a one-cycle error output. Such a read returns zero and such a write changes nothing.

The access sequencer is a four-state machine, one state per cycle after a request:
- ACC_IDLE: no request was seen in the previous cycle.
- ACC_READ: a valid read was accepted, and its data is on the read bus.
- ACC_WRITE: a valid write was accepted.
- ACC_FAULT: the previous request hit an absent or unknown offset.

Every state is left or kept on each clock edge, and all transitions are unconditional on the old state:
- idle request: to ACC_IDLE when there is no valid request.
- fault: to ACC_FAULT on a valid request to an absent offset.
- write accept: to ACC_WRITE on a valid write to a present offset.
- read accept: to ACC_READ on a valid read to a present offset.

Top module: `brd_sysctl_regs`

## Requirements
- R1: After reset the words read as follows. The control word at 0x000 holds parameter CFG0_RST. The words at 0x004, 0x008, 0x014 and 0x018 hold zero. The lock word at 0x100 reads 0xFFFF0001 while all eight lock inputs are high. remap_out equals bit 0 of CFG0_RST and led_out is zero.
- R2: A valid read places its data on rsp_rdata in the cycle after the request. In any cycle that does not follow a valid read, rsp_rdata is zero.
- R3: A write to offset 0x000 stores all 32 bits. From the cycle after the write, remap_out equals bit 0 of the stored word.
- R4: A write to offset 0x004 stores all 32 bits. From the cycle after the write, led_out[i] equals bit i of the stored word.
- R5: Offset 0x00C always reads zero. Offset 0x010 reads CFG4_VAL, offset 0xFF8 reads AUXID_VAL and offset 0xFFC reads ID_VAL. Writes to these four offsets change nothing and raise no error.
- R6: The part number is ID_VAL bits [11:4]. Offsets 0x008 and 0x014 are read/write words only when the part number equals PN_A or PN_B. Offset 0x018 is a read/write word only when it equals PN_A. Otherwise these offsets are absent.
- R7: A valid request to an absent offset, an unknown offset or an offset not aligned to 4 bytes raises bad_access in the cycle after the request. Such a read returns zero and such a write has no effect. bad_access is low in every other cycle.
- R8: In the lock word at 0x100, only bits [31:24] (the loop mask, reset value 0xFF) are writable. Bits [23:16] read the loop_locked input, and bits [15:1] read zero.
- R9: Bit 0 of the lock word reads 1 exactly when every loop selected by the mask is locked, that is when (mask & loop_locked) == mask at the time of the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the 4 KB window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the cycle after a read request |
| bad_access | output | 1 | One-cycle flag for a request to an absent or unknown offset |
| remap_out | output | 1 | Boot-remap control, bit 0 of the control word |
| led_out | output | LED_N | LED drive, low bits of the LED word |
| loop_locked | input | 8 | Per-loop locked flags |

## Verification
Every result of a request appears exactly one clock edge after that request. This covers read data, the error flag, and the remap and LED outputs after a write. The lock summary uses the loop_locked value present on the request edge. The reference model in the bench sees the same edge as the design. It computes the expected outputs when that edge arrives and compares them with the design's outputs at the following falling edge, while the next request is being driven. Three copies of the block, built for the two designated part numbers and for an unrelated one, take the same stimulus, so each variant's set of present offsets is checked side by side.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int WIN_AW = 12;
    localparam int LOOP_N = 8;

    localparam logic [WIN_AW-1:0] OFS_CFG0  = 12'h000;
    localparam logic [WIN_AW-1:0] OFS_CFG1  = 12'h004;
    localparam logic [WIN_AW-1:0] OFS_CFG2  = 12'h008;
    localparam logic [WIN_AW-1:0] OFS_CFG3  = 12'h00C;
    localparam logic [WIN_AW-1:0] OFS_CFG4  = 12'h010;
    localparam logic [WIN_AW-1:0] OFS_CFG5  = 12'h014;
    localparam logic [WIN_AW-1:0] OFS_CFG6  = 12'h018;
    localparam logic [WIN_AW-1:0] OFS_LOCK  = 12'h100;
    localparam logic [WIN_AW-1:0] OFS_AUXID = 12'hFF8;
    localparam logic [WIN_AW-1:0] OFS_ID    = 12'hFFC;

    typedef enum logic [3:0] {
        SEL_CFG0, SEL_CFG1, SEL_CFG2, SEL_CFG3, SEL_CFG4,
        SEL_CFG5, SEL_CFG6, SEL_LOCK, SEL_AUXID, SEL_ID, SEL_NONE
    } reg_sel_e;

    typedef enum logic [1:0] {
        ACC_IDLE, ACC_READ, ACC_WRITE, ACC_FAULT
    } acc_state_e;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter logic [7:0] PN_A = 8'h24,
    parameter logic [7:0] PN_B = 8'h47
) (
    input  logic [WIN_AW-1:0] addr,
    input  logic [7:0]        part_no,
    output reg_sel_e          sel,
    output logic              present
);
    logic pair_ok;
    logic first_ok;

    always_comb begin
        pair_ok  = (part_no == PN_A) || (part_no == PN_B);
        first_ok = (part_no == PN_A);
        case (addr)
            OFS_CFG0:  sel = SEL_CFG0;
            OFS_CFG1:  sel = SEL_CFG1;
            OFS_CFG2:  sel = pair_ok  ? SEL_CFG2 : SEL_NONE;
            OFS_CFG3:  sel = SEL_CFG3;
            OFS_CFG4:  sel = SEL_CFG4;
            OFS_CFG5:  sel = pair_ok  ? SEL_CFG5 : SEL_NONE;
            OFS_CFG6:  sel = first_ok ? SEL_CFG6 : SEL_NONE;
            OFS_LOCK:  sel = SEL_LOCK;
            OFS_AUXID: sel = SEL_AUXID;
            OFS_ID:    sel = SEL_ID;
            default:   sel = SEL_NONE;
        endcase
        present = (sel != SEL_NONE);
    end
endmodule

// File: rtl/sysctl_access_fsm.sv
module sysctl_access_fsm
    import sysctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       present,
    output logic       wr_en,
    output logic       rd_en,
    output logic       bad_access,
    output logic       rsp_live
);
    acc_state_e state;
    acc_state_e state_nxt;

    always_comb begin
        if (!req_valid)     state_nxt = ACC_IDLE;
        else if (!present)  state_nxt = ACC_FAULT;
        else if (req_write) state_nxt = ACC_WRITE;
        else                state_nxt = ACC_READ;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ACC_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        wr_en = req_valid && req_write && present;
        rd_en = req_valid && !req_write && present;
        bad_access = 1'b0;
        rsp_live   = 1'b0;
        unique case (state)
            ACC_IDLE:  ;
            ACC_READ:  rsp_live   = 1'b1;
            ACC_WRITE: ;
            ACC_FAULT: bad_access = 1'b1;
        endcase
    end

    assert_fault_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> $past(req_valid && !present));

    assert_read_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_live |-> $past(req_valid && !req_write && present));
endmodule

// File: rtl/sysctl_lockstat.sv
module sysctl_lockstat
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LOOP_N-1:0] new_mask,
    input  logic [LOOP_N-1:0] locked,
    output logic [31:0]       word
);
    logic [LOOP_N-1:0] mask;
    logic              all_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     mask <= '1;
        else if (wr_en) mask <= new_mask;
    end

    always_comb begin
        all_ok = ((mask & locked) == mask);
        word   = {mask, locked, 15'b0, all_ok};
    end

    assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (mask == $past(mask)));
endmodule

// File: rtl/brd_sysctl_regs.sv
module brd_sysctl_regs
    import sysctl_pkg::*;
#(
    parameter logic [31:0] CFG0_RST  = 32'h0000_0003,
    parameter logic [31:0] CFG4_VAL  = 32'h0000_0102,
    parameter logic [31:0] AUXID_VAL = 32'h0201_0011,
    parameter logic [31:0] ID_VAL    = 32'h4104_1240,
    parameter logic [7:0]  PN_A      = 8'h24,
    parameter logic [7:0]  PN_B      = 8'h47,
    parameter int          LED_N     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [11:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata,
    output logic              bad_access,
    output logic              remap_out,
    output logic [LED_N-1:0]  led_out,
    input  logic [7:0]        loop_locked
);
    localparam logic [7:0] PART_NO   = ID_VAL[11:4];
    localparam bit         HAS_PAIR  = (PART_NO == PN_A) || (PART_NO == PN_B);
    localparam bit         HAS_FIRST = (PART_NO == PN_A);

    reg_sel_e    sel;
    logic        present;
    logic        wr_en;
    logic        rd_en;
    logic        rsp_live;
    logic [31:0] lock_word;
    logic [31:0] cfg0_q;
    logic [31:0] cfg1_q;
    logic [31:0] cfg2_q;
    logic [31:0] cfg5_q;
    logic [31:0] cfg6_q;
    logic [31:0] rd_mux;
    logic [31:0] rd_hold;

    sysctl_decode #(.PN_A(PN_A), .PN_B(PN_B)) u_dec (
        .addr    (req_addr),
        .part_no (PART_NO),
        .sel     (sel),
        .present (present)
    );

    sysctl_access_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .present    (present),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .bad_access (bad_access),
        .rsp_live   (rsp_live)
    );

    sysctl_lockstat u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en && (sel == SEL_LOCK)),
        .new_mask (req_wdata[31:24]),
        .locked   (loop_locked),
        .word     (lock_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg0_q <= CFG0_RST;
            cfg1_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_CFG0) cfg0_q <= req_wdata;
            if (sel == SEL_CFG1) cfg1_q <= req_wdata;
        end
    end

    generate
        if (HAS_PAIR) begin : g_pair
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cfg2_q <= '0;
                    cfg5_q <= '0;
                end else if (wr_en) begin
                    if (sel == SEL_CFG2) cfg2_q <= req_wdata;
                    if (sel == SEL_CFG5) cfg5_q <= req_wdata;
                end
            end
        end else begin : g_no_pair
            assign cfg2_q = '0;
            assign cfg5_q = '0;
        end

        if (HAS_FIRST) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                        cfg6_q <= '0;
                else if (wr_en && sel == SEL_CFG6) cfg6_q <= req_wdata;
            end
        end else begin : g_no_first
            assign cfg6_q = '0;
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SEL_CFG0:  rd_mux = cfg0_q;
            SEL_CFG1:  rd_mux = cfg1_q;
            SEL_CFG2:  rd_mux = cfg2_q;
            SEL_CFG3:  rd_mux = '0;
            SEL_CFG4:  rd_mux = CFG4_VAL;
            SEL_CFG5:  rd_mux = cfg5_q;
            SEL_CFG6:  rd_mux = cfg6_q;
            SEL_LOCK:  rd_mux = lock_word;
            SEL_AUXID: rd_mux = AUXID_VAL;
            SEL_ID:    rd_mux = ID_VAL;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_hold <= '0;
        else if (rd_en) rd_hold <= rd_mux;
    end

    assign rsp_rdata = rsp_live ? rd_hold : '0;
    assign remap_out = cfg0_q[0];

    generate
        for (genvar i = 0; i < LED_N; i++) begin : g_led
            assign led_out[i] = cfg1_q[i];
        end
    endgenerate

    assert_remap_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == OFS_CFG0) |=> (remap_out == $past(req_wdata[0])));

    assert_led_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == OFS_CFG1) |=> (led_out == $past(req_wdata[LED_N-1:0])));

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> (rsp_rdata == 32'h0));

    assert_id_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == OFS_ID) |=> (rsp_rdata == ID_VAL));

    assert_absent_cfg6_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == OFS_CFG6 && PART_NO != PN_A) |=> bad_access);
endmodule

// File: tb/sim_brd_sysctl_regs.sv
module sim_brd_sysctl_regs;
    localparam logic [31:0] C0_RST = 32'h0000_0003;
    localparam logic [31:0] C4_VAL = 32'h0000_0102;
    localparam logic [31:0] AUXV   = 32'h0201_0011;
    localparam logic [7:0]  PNA    = 8'h24;
    localparam logic [7:0]  PNB    = 8'h47;
    localparam logic [31:0] IDV0   = 32'h4104_1240;
    localparam logic [31:0] IDV1   = 32'h4104_1470;
    localparam logic [31:0] IDV2   = 32'h4104_1110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  loop_locked = 8'hFF;
    string       req_tag = "R2";

    logic [31:0] rdata [3];
    logic        bad   [3];
    logic        remap [3];
    logic [7:0]  led   [3];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    brd_sysctl_regs #(.CFG0_RST(C0_RST), .CFG4_VAL(C4_VAL), .AUXID_VAL(AUXV),
        .ID_VAL(IDV0), .PN_A(PNA), .PN_B(PNB), .LED_N(8)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rdata[0]),
        .bad_access(bad[0]), .remap_out(remap[0]), .led_out(led[0]),
        .loop_locked(loop_locked));

    brd_sysctl_regs #(.CFG0_RST(C0_RST), .CFG4_VAL(C4_VAL), .AUXID_VAL(AUXV),
        .ID_VAL(IDV1), .PN_A(PNA), .PN_B(PNB), .LED_N(8)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rdata[1]),
        .bad_access(bad[1]), .remap_out(remap[1]), .led_out(led[1]),
        .loop_locked(loop_locked));

    brd_sysctl_regs #(.CFG0_RST(C0_RST), .CFG4_VAL(C4_VAL), .AUXID_VAL(AUXV),
        .ID_VAL(IDV2), .PN_A(PNA), .PN_B(PNB), .LED_N(8)) u2 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rdata[2]),
        .bad_access(bad[2]), .remap_out(remap[2]), .led_out(led[2]),
        .loop_locked(loop_locked));

    // Reference model state, one set per copy
    logic [31:0] m_w0 [3];
    logic [31:0] m_w1 [3];
    logic [31:0] m_w2 [3];
    logic [31:0] m_w5 [3];
    logic [31:0] m_w6 [3];
    logic [7:0]  m_mask [3];
    logic [31:0] e_rdata [3];
    logic        e_bad [3];
    string       e_tag = "R2";

    function automatic logic [7:0] pn_of(int k);
        case (k)
            0: return IDV0[11:4];
            1: return IDV1[11:4];
            default: return IDV2[11:4];
        endcase
    endfunction

    function automatic logic [31:0] id_of(int k);
        case (k)
            0: return IDV0;
            1: return IDV1;
            default: return IDV2;
        endcase
    endfunction

    function automatic bit exists(int k, logic [11:0] a);
        logic [7:0] p = pn_of(k);
        case (a)
            12'h000, 12'h004, 12'h00C, 12'h010, 12'h100, 12'hFF8, 12'hFFC: return 1'b1;
            12'h008, 12'h014: return (p == PNA) || (p == PNB);
            12'h018: return p == PNA;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] model_read(int k, logic [11:0] a, logic [7:0] lk);
        case (a)
            12'h000: return m_w0[k];
            12'h004: return m_w1[k];
            12'h008: return m_w2[k];
            12'h010: return C4_VAL;
            12'h014: return m_w5[k];
            12'h018: return m_w6[k];
            12'h100: return {m_mask[k], lk, 15'b0, ((m_mask[k] & lk) == m_mask[k])};
            12'hFF8: return AUXV;
            12'hFFC: return id_of(k);
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < 3; k++) begin
            if (!rst_n) begin
                m_w0[k] = C0_RST; m_w1[k] = 0; m_w2[k] = 0; m_w5[k] = 0; m_w6[k] = 0;
                m_mask[k] = 8'hFF; e_rdata[k] = 0; e_bad[k] = 0;
            end else begin
                e_rdata[k] = 0;
                e_bad[k]   = 0;
                if (req_valid) begin
                    if (!exists(k, req_addr)) e_bad[k] = 1;
                    else if (!req_write) e_rdata[k] = model_read(k, req_addr, loop_locked);
                    else begin
                        case (req_addr)
                            12'h000: m_w0[k] = req_wdata;
                            12'h004: m_w1[k] = req_wdata;
                            12'h008: m_w2[k] = req_wdata;
                            12'h014: m_w5[k] = req_wdata;
                            12'h018: m_w6[k] = req_wdata;
                            12'h100: m_mask[k] = req_wdata[31:24];
                            default: ;
                        endcase
                    end
                end
            end
        end
        e_tag = (rst_n && req_valid) ? req_tag : "R2";
    end

    task automatic check(bit ok, string tag, int k, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s copy%0d %s actual=%h expected=%h", tag, k, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int k = 0; k < 3; k++) begin
                check(rdata[k] === e_rdata[k], e_tag, k, "rsp_rdata", rdata[k], e_rdata[k]);
                check(bad[k] === e_bad[k], "R7", k, "bad_access", {31'b0, bad[k]}, {31'b0, e_bad[k]});
                check(remap[k] === m_w0[k][0], "R3", k, "remap_out", {31'b0, remap[k]}, {31'b0, m_w0[k][0]});
                check(led[k] === m_w1[k][7:0], "R4", k, "led_out", {24'b0, led[k]}, {24'b0, m_w1[k][7:0]});
            end
        end
    end

    task automatic rd(logic [11:0] a, string tag);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_wdata = 32'hDEAD_BEEF; req_tag = tag;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_tag = tag;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 0; req_write = 0; req_tag = "R2";
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values seen through the bus
        rd(12'h000, "R1"); rd(12'h004, "R1"); rd(12'h008, "R1"); rd(12'h014, "R1");
        rd(12'h018, "R1"); rd(12'h100, "R1");
        idle(); idle();
        // R3: control word and remap line
        wr(12'h000, 32'hA5A5_0000, "R3"); rd(12'h000, "R3");
        wr(12'h000, 32'h1234_5677, "R3"); idle(); rd(12'h000, "R3");
        // R4: LED word
        wr(12'h004, 32'hFFFF_FFC3, "R4"); rd(12'h004, "R4");
        wr(12'h004, 32'h0000_003C, "R4"); rd(12'h004, "R4");
        // R6: variant words
        wr(12'h008, 32'h1111_2222, "R6"); wr(12'h014, 32'h3333_4444, "R6");
        wr(12'h018, 32'h5555_6666, "R6");
        rd(12'h008, "R6"); rd(12'h014, "R6"); rd(12'h018, "R6");
        // R5: fixed words, writes ignored
        wr(12'h00C, 32'hFFFF_FFFF, "R5"); wr(12'h010, 32'hFFFF_FFFF, "R5");
        wr(12'hFF8, 32'h0, "R5"); wr(12'hFFC, 32'h0, "R5");
        rd(12'h00C, "R5"); rd(12'h010, "R5"); rd(12'hFF8, "R5"); rd(12'hFFC, "R5");
        // R7: unknown and unaligned offsets
        wr(12'h020, 32'hFFFF_FFFF, "R7"); rd(12'h020, "R7");
        wr(12'h002, 32'hFFFF_FFFF, "R7"); rd(12'h001, "R7");
        rd(12'h104, "R7"); wr(12'h800, 32'h1, "R7"); idle();
        rd(12'h000, "R7"); rd(12'h004, "R7");
        // R8/R9: lock word mask and summary
        wr(12'h100, 32'h1234_5678, "R8"); rd(12'h100, "R8");
        loop_locked = 8'h12; rd(12'h100, "R9");
        loop_locked = 8'h10; rd(12'h100, "R9");
        loop_locked = 8'h00; wr(12'h100, 32'h00FF_FFFF, "R8"); rd(12'h100, "R9");
        loop_locked = 8'hFE; wr(12'h100, 32'h81FF_FFFF, "R8"); rd(12'h100, "R9");
        loop_locked = 8'hFF; rd(12'h100, "R9");
        idle();
        // Mixed traffic over all offsets
        for (int n = 0; n < 400; n++) begin
            logic [11:0] a;
            case ($urandom_range(0, 13))
                0: a = 12'h000;  1: a = 12'h004;  2: a = 12'h008;  3: a = 12'h00C;
                4: a = 12'h010;  5: a = 12'h014;  6: a = 12'h018;  7: a = 12'h100;
                8: a = 12'hFF8;  9: a = 12'hFFC;  10: a = 12'h01C; 11: a = 12'h006;
                12: a = 12'hFF4; default: a = 12'h100;
            endcase
            loop_locked = 8'($urandom);
            case ($urandom_range(0, 2))
                0: rd(a, "R2");
                1: wr(a, $urandom, "R2");
                default: idle();
            endcase
        end
        idle(); idle();
        @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule